// File: doc/BRIEF.md
# Configuration Stream Sync Hunter

This block sits at the head of a byte-wide configuration input path. Bytes arrive over a valid/ready handshake. The block first discards any optional comment header and then searches for a 32-bit synchronisation word, 0x7EAA997E. The four bytes of that word arrive most significant byte first. A comment header opens with 0xFF 0x00 and holds zero-terminated text strings. It is usually closed by 0x00 0xFF, but that closing pair can land inside the text. For that reason the block never relies on the framing. It keeps comparing a sliding window of the last four accepted bytes against the sync word, whatever header state it appears to be in.

Once the final byte of the sync word has been accepted, the block raises `locked`. From then on it is a zero-latency pass-through to the downstream command interpreter. If a configurable number of bytes goes by before lock, the block raises `hdrError` and refuses further input until reset. The reset is synchronous and active high, and it returns the block to hunting.

Top module: `cfgsync_hunter`

## Requirements
- R1: After reset, `locked` = 0, `hdrError` = 0, `outValid` = 0 and `inReady` = 1.
- R2: While hunting (neither `locked` nor `hdrError`), `inReady` is 1 and `outValid` is 0, so no byte reaches the output.
- R3: The sync word 0x7EAA997E, sent as bytes 7E, AA, 99, 7E in that order, is found at any byte offset of the stream. `locked` rises on the clock edge that accepts its last byte and is visible in the following cycle.
- R4: Header framing bytes (FF 00 opener, 00 string terminators, 00 FF closer, including a closer placed inside comment text) and incomplete sync-word prefixes have no effect. Only the complete sync word causes lock.
- R5: While `locked`, `outValid` equals `inValid`, `outData` equals `inData`, and `inReady` equals `outReady`, combinationally in the same cycle.
- R6: No byte of the sync word is forwarded. The first byte offered downstream is the first byte accepted after the sync word's last byte.
- R7: With limit `MAX_HDR` (a parameter), if the `MAX_HDR`-th accepted pre-lock byte does not complete the sync word, `hdrError` rises in the next cycle. From then on `inReady` = 0 and `outValid` = 0. A sync word whose last byte is exactly the `MAX_HDR`-th accepted byte still locks without error.
- R8: `locked` and `hdrError` each stay high until reset, and they are never high together.
- R9: Cycles with `inValid` = 0 are neither shifted into the window nor counted against the limit. A sync word split by idle cycles is still found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Upstream byte valid |
| inData | input | 8 | Upstream byte |
| inReady | output | 1 | Block accepts the upstream byte |
| outValid | output | 1 | Downstream byte valid (only after lock) |
| outData | output | 8 | Downstream byte |
| outReady | input | 1 | Downstream accepts the byte |
| locked | output | 1 | Sync word found; pass-through active |
| hdrError | output | 1 | Byte limit reached without sync word; input blocked |

## Verification
Two functions can meet in one cycle. One is completion of the sync word, which triggers lock. The other is exhaustion of the header byte limit, which triggers the error. The bench uses a limit of 16 and sweeps the amount of filler in front of the sync word across the whole range, so that the word's last byte falls before, exactly on, and past the final permitted byte. In each case it judges which of `locked` and `hdrError` is high, computing the expected outcome from the offset: lock if offset + 4 ≤ 16. Sync-word completion must win when both happen on the same byte.

// File: rtl/cfgsync_pkg.sv
package cfgsync_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // push accepted byte into the history window
    logic countEn;  // advance the pre-lock byte counter
  } cfgStrobes_t;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LOCK = 2'd1,
    ST_FAIL = 2'd2
  } hunterState_t;
endpackage

// File: rtl/cfgsync_dp.sv
module cfgsync_dp
  import cfgsync_pkg::*;
#(
  parameter int          MAX_HDR     = 4096,
  parameter int          TOKEN_BYTES = 4,
  parameter logic [31:0] TOKEN       = 32'h7EAA997E
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  inData,
  input  cfgStrobes_t strb,
  output logic        tokenHit,
  output logic        lastSlot,
  output logic [7:0]  outData
);
  localparam int HIST  = TOKEN_BYTES - 1;
  localparam int CNT_W = (MAX_HDR > 2) ? $clog2(MAX_HDR) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_HDR - 1);

  logic [7:0]       lane [HIST];
  logic [CNT_W-1:0] hdrCnt;
  logic [8*TOKEN_BYTES-1:0] window;

  // History window: lane[0] holds the newest stored byte
  always_ff @(posedge clk) begin
    if (rst)              lane[0] <= '0;
    else if (strb.shiftEn) lane[0] <= inData;
  end

  for (genvar g = 1; g < HIST; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)               lane[g] <= '0;
      else if (strb.shiftEn) lane[g] <= lane[g-1];
    end
  end

  // Window = oldest byte in the MSBs, incoming byte in the LSBs
  always_comb begin
    window = '0;
    window[7:0] = inData;
    for (int k = 0; k < HIST; k++) begin
      window[8*(k+1) +: 8] = lane[k];
    end
  end

  assign tokenHit = (window == TOKEN[8*TOKEN_BYTES-1:0]);

  always_ff @(posedge clk) begin
    if (rst)               hdrCnt <= '0;
    else if (strb.countEn) hdrCnt <= hdrCnt + 1'b1;
  end

  assign lastSlot = (hdrCnt == LAST);
  assign outData  = inData;
endmodule

// File: rtl/cfgsync_ctrl.sv
module cfgsync_ctrl
  import cfgsync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        tokenHit,
  input  logic        lastSlot,
  output cfgStrobes_t strb,
  output logic        inReady,
  output logic        outValid,
  output logic        locked,
  output logic        hdrError
);
  hunterState_t state, stateNext;
  logic huntTake;

  assign huntTake = (state == ST_HUNT) && inValid;

  always_comb begin
    stateNext = state;
    if (huntTake) begin
      if (tokenHit)      stateNext = ST_LOCK;
      else if (lastSlot) stateNext = ST_FAIL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_HUNT;
    else     state <= stateNext;
  end

  always_comb begin
    strb.shiftEn = huntTake;
    strb.countEn = huntTake;
    case (state)
      ST_HUNT: begin inReady = 1'b1;     outValid = 1'b0;    end
      ST_LOCK: begin inReady = outReady; outValid = inValid; end
      default: begin inReady = 1'b0;     outValid = 1'b0;    end
    endcase
  end

  assign locked   = (state == ST_LOCK);
  assign hdrError = (state == ST_FAIL);
endmodule

// File: rtl/cfgsync_hunter.sv
module cfgsync_hunter
  import cfgsync_pkg::*;
#(
  parameter int          MAX_HDR = 4096,
  parameter logic [31:0] TOKEN   = 32'h7EAA997E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  output logic       outValid,
  output logic [7:0] outData,
  input  logic       outReady,
  output logic       locked,
  output logic       hdrError
);
  cfgStrobes_t strb;
  logic tokenHit, lastSlot;

  cfgsync_dp #(.MAX_HDR(MAX_HDR), .TOKEN_BYTES(4), .TOKEN(TOKEN)) u_dp (
    .clk(clk), .rst(rst), .inData(inData), .strb(strb),
    .tokenHit(tokenHit), .lastSlot(lastSlot), .outData(outData)
  );

  cfgsync_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .tokenHit(tokenHit), .lastSlot(lastSlot), .strb(strb),
    .inReady(inReady), .outValid(outValid), .locked(locked), .hdrError(hdrError)
  );
endmodule

// File: rtl/cfgsync_chk.sv
module cfgsync_chk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outReady,
  input logic       locked,
  input logic       hdrError
);
  // R2
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && !hdrError) |-> (inReady && !outValid));

  // R5
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (outValid == inValid && inReady == outReady && outData == inData));

  // R3
  lock_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(inValid && inReady));

  // R7
  error_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    hdrError |-> (!inReady && !outValid));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R8
  error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    hdrError |=> hdrError);

  // R8
  never_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(locked && hdrError));
endmodule

bind cfgsync_hunter cfgsync_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady),
  .locked(locked), .hdrError(hdrError)
);

// File: tb/sim_cfgsync_hunter.sv
`timescale 1ns/1ps
module sim_cfgsync_hunter;
  localparam int LIMIT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic outReady = 1'b0;
  logic inReady, outValid, locked, hdrError;
  logic [7:0] outData;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cfgsync_hunter #(.MAX_HDR(LIMIT)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .locked(locked), .hdrError(hdrError)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; inValid = 1'b0; outReady = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); inValid = 1'b1; inData = b;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); inValid = 1'b0; inData = 8'h7E;
      @(posedge clk);
    end
  endtask

  task automatic stopSend();
    @(negedge clk); inValid = 1'b0;
  endtask

  // Sends the sync word; checks that the last byte is not forwarded (R6)
  task automatic sendToken();
    sendByte(8'h7E); sendByte(8'hAA); sendByte(8'h99);
    @(negedge clk); inValid = 1'b1; inData = 8'h7E;
    chk(outValid == 1'b0 && locked == 1'b0, "R6 last sync byte not forwarded",
        {locked, outValid}, 0);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    chk(!locked && !hdrError && !outValid && inReady, "R1 reset state",
        {locked, hdrError, outValid, inReady}, 4'b0001);

    // R4 well-formed header then sync word
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h41); sendByte(8'h42);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'hFF);
    stopSend();
    chk(!locked && inReady && !outValid, "R4/R2 framed header no lock", locked, 0);
    sendToken(); stopSend();
    chk(locked == 1'b1, "R4 lock after framed header", locked, 1);

    // R4 misplaced closer inside comment text
    doReset();
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h43); sendByte(8'h00);
    sendByte(8'hFF); sendByte(8'h44); sendByte(8'h00);
    stopSend();
    chk(!locked && !hdrError, "R4 misplaced closer ignored", locked, 0);
    sendToken(); stopSend();
    chk(locked == 1'b1, "R4 lock after misplaced closer", locked, 1);

    // R4 partial sync prefix inside comment does not lock
    doReset();
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h7E); sendByte(8'hAA);
    sendByte(8'h99); sendByte(8'h00);
    stopSend();
    chk(locked == 1'b0, "R4 partial prefix no lock", locked, 0);
    sendToken(); stopSend();
    chk(locked == 1'b1, "R4 lock after partial prefix", locked, 1);

    // R5 / R6 pass-through sweep over valid/ready combinations
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      outReady = i[0]; inValid = i[1]; inData = 8'h80 + 8'(i);
      #0.5;
      chk(outValid == i[1] && inReady == i[0] && outData == 8'h80 + 8'(i),
          "R5 pass-through", {outValid, inReady, outData}, {i[1], i[0], 8'h80 + 8'(i)});
      @(posedge clk);
    end
    stopSend();
    chk(locked == 1'b1 && hdrError == 1'b0, "R8 lock sticky", locked, 1);
    doReset();
    chk(locked == 1'b0 && inReady == 1'b1, "R8 reset clears lock", locked, 0);

    // R3 / R7 offset sweep across the byte limit
    for (int off = 0; off <= LIMIT - 1; off++) begin
      bit expLock;
      expLock = (off + 4 <= LIMIT);
      doReset();
      for (int j = 0; j < off; j++) sendByte(8'h10 + 8'(j));
      sendByte(8'h7E); sendByte(8'hAA); sendByte(8'h99); sendByte(8'h7E);
      stopSend();
      chk(locked == expLock && hdrError == !expLock, "R3/R7 offset sweep",
          {locked, hdrError}, {expLock, !expLock});
      if (!expLock)
        chk(inReady == 1'b0 && outValid == 1'b0, "R7 input blocked", inReady, 0);
    end

    // R7 pure filler reaches limit
    doReset();
    for (int j = 0; j < LIMIT - 1; j++) sendByte(8'h20);
    stopSend();
    chk(hdrError == 1'b0, "R7 no error before limit", hdrError, 0);
    sendByte(8'h20); stopSend();
    chk(hdrError == 1'b1 && inReady == 1'b0, "R7 error at limit", hdrError, 1);
    // R8 sync word after error is refused
    sendToken(); stopSend();
    chk(hdrError == 1'b1 && locked == 1'b0 && inReady == 1'b0,
        "R8 error sticky", {hdrError, locked}, 2'b10);

    // R9 idle cycles neither shift nor count
    doReset();
    for (int j = 0; j < LIMIT - 4; j++) sendByte(8'h30);
    sendByte(8'h7E); sendByte(8'hAA);
    idle(10);
    sendByte(8'h99); sendByte(8'h7E);
    stopSend();
    chk(locked == 1'b1 && hdrError == 1'b0, "R9 split sync word with idles",
        {locked, hdrError}, 2'b10);

    // R6 first forwarded byte is the one after the sync word
    @(negedge clk); outReady = 1'b1; inValid = 1'b1; inData = 8'h5A;
    #0.5;
    chk(outValid == 1'b1 && outData == 8'h5A, "R6 first forwarded byte", outData, 8'h5A);
    @(posedge clk);
    stopSend();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule